// File: doc/BRIEF.md
# UART Transmit Queue with Occupancy and Threshold Status

This block sits between a processor's write port and a UART transmit shift register. Each byte the processor writes is held in a 24-entry first-in first-out queue. When the shift register asks for its next character, the block hands over the oldest byte. If the queue has data, it acknowledges the request in the same cycle and removes that byte from the queue.

Besides plain full and empty, the block reports several kinds of status. It gives the exact number of queued bytes, from 0 to 24. It raises a ready flag while a slot is free. A threshold flag rises once the number of free slots reaches a level that software sets. A transmitter-empty flag rises only after an underrun: the shift register has finished a character, found nothing to send, and is now idle.

The ready flag and the threshold flag each drive the single interrupt line, and each has its own enable. Serial bit timing, framing and parity are handled elsewhere.

Top module: `uart_txq`

## Requirements
- R1: `count` equals the number of accepted writes minus the number of acknowledged loads since reset, and always lies between 0 and 24.
- R2: A write while `count` is 24 is ignored: `count` does not rise and the queued bytes are unchanged.
- R3: `txReady` is 1 exactly when `count` is below 24.
- R4: `loadAck` is 1 exactly when `loadReq` is 1 and `count` is not 0. `txByte` shows the oldest queued byte, so bytes leave in the order they were written. A load request on an empty queue changes nothing.
- R5: An underrun is recorded when `shiftDone` is 1 while `count` is 0 and no write is accepted in that cycle. The shift register counts as busy from an acknowledged load until `shiftDone`. `txEmpty` is 1 exactly when an underrun is recorded, `count` is 0 and the shift register is idle.
- R6: An accepted write clears the recorded underrun, so `txEmpty` is 0 from the next cycle on.
- R7: `threshHit` is 1 exactly when (24 − `count`) ≥ `thresh`, with `thresh` read as an unsigned 5-bit number.
- R8: `irq` equals (`irqEnReady` AND `txReady`) OR (`irqEnThresh` AND `threshHit`).
- R9: After reset, `count` is 0, `txReady` is 1, `txEmpty` is 0 and no underrun is recorded.
- R10: A write and an acknowledged load in the same cycle leave `count` unchanged and keep the byte order. When the queue is full, the write is still refused in that cycle, so `count` falls to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor write strobe |
| wrData | input | 8 | Byte to queue |
| loadReq | input | 1 | Shift register asks for the next byte |
| shiftDone | input | 1 | Shift register has finished its character |
| thresh | input | 5 | Programmed emptiness level |
| irqEnReady | input | 1 | Lets the ready flag drive the interrupt |
| irqEnThresh | input | 1 | Lets the threshold flag drive the interrupt |
| txByte | output | 8 | Oldest queued byte, offered to the shift register |
| loadAck | output | 1 | Load request served this cycle |
| txReady | output | 1 | At least one slot is free |
| txEmpty | output | 1 | Underrun recorded, queue empty and shift register idle |
| threshHit | output | 1 | Free-slot count has reached `thresh` |
| count | output | 5 | Number of queued bytes, 0 to 24 |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can happen in one cycle: a processor write arrives while the shift register's load request is served. The bench forces this on purpose. It fills the queue to 24 and then drives a write and a load together. It also mixes the two at random, with bias phases that push the queue toward full and toward empty. Each time, it checks `count` and the order of later `txByte` values against a reference queue in the bench. A second overlap is tested too: a write in the same cycle as an underrun `shiftDone`. The expected result is that the write wins, so `txEmpty` stays 0.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          loadReq,
  input  logic          shiftDone,
  input  logic [CW-1:0] thresh,
  input  logic          irqEnReady,
  input  logic          irqEnThresh,
  output qStrobe_t      strobe,
  output logic [CW-1:0] count,
  output logic          txReady,
  output logic          txEmpty,
  output logic          threshHit,
  output logic          loadAck,
  output logic          irq
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [CW-1:0] countQ;
  logic          busyQ;
  logic          underrunQ;
  logic          isFull;
  logic          isEmpty;
  logic [CW-1:0] freeSlots;

  assign isFull  = (countQ == FULLV);
  assign isEmpty = (countQ == '0);

  always_comb begin
    strobe.push = wrEn & ~isFull;
    strobe.pop  = loadReq & ~isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   countQ <= countQ + CW'(1);
        2'b01:   countQ <= countQ - CW'(1);
        default: countQ <= countQ;
      endcase
    end
  end

  // shift register occupancy as seen from the queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.pop) begin
      busyQ <= 1'b1;
    end else if (shiftDone) begin
      busyQ <= 1'b0;
    end
  end

  // underrun record: write wins over a simultaneous empty finish
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrunQ <= 1'b0;
    end else if (strobe.push) begin
      underrunQ <= 1'b0;
    end else if (shiftDone && isEmpty) begin
      underrunQ <= 1'b1;
    end
  end

  assign freeSlots = FULLV - countQ;
  assign threshHit = (freeSlots >= thresh);
  assign txReady   = ~isFull;
  assign txEmpty   = underrunQ & isEmpty & ~busyQ;
  assign loadAck   = strobe.pop;
  assign count     = countQ;
  assign irq       = (irqEnReady & txReady) | (irqEnThresh & threshHit);
endmodule

// File: rtl/txq_data.sv
module txq_data
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int WIDTH = 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData
);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             loadReq,
  input  logic             shiftDone,
  input  logic [CW-1:0]    thresh,
  input  logic             irqEnReady,
  input  logic             irqEnThresh,
  output logic [WIDTH-1:0] txByte,
  output logic             loadAck,
  output logic             txReady,
  output logic             txEmpty,
  output logic             threshHit,
  output logic [CW-1:0]    count,
  output logic             irq
);
  qStrobe_t strobe;

  txq_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrlI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .loadReq(loadReq),
    .shiftDone(shiftDone), .thresh(thresh), .irqEnReady(irqEnReady),
    .irqEnThresh(irqEnThresh), .strobe(strobe), .count(count),
    .txReady(txReady), .txEmpty(txEmpty), .threshHit(threshHit),
    .loadAck(loadAck), .irq(irq)
  );

  txq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dataI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .headData(txByte)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          loadAck,
  input logic          txReady,
  input logic          txEmpty,
  input logic          threshHit,
  input logic [CW-1:0] thresh,
  input logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULLV);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + CW'(1))
             || (count + CW'(1) == $past(count)));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULLV && wrEn && !loadAck) |=> count == FULLV);

  // R3
  ready_low_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txReady |-> count == FULLV);

  // R4
  no_ack_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    count == '0 |-> !loadAck);

  // R5
  empty_needs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> count == '0);

  // R6
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txReady) |=> !txEmpty);

  // R7
  thresh_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && thresh <= FULLV) |-> threshHit);
endmodule

bind uart_txq txq_chk #(.DEPTH(DEPTH), .CW(CW)) chkI (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .loadAck(loadAck),
  .txReady(txReady), .txEmpty(txEmpty), .threshHit(threshHit),
  .thresh(thresh), .count(count)
);

// File: tb/tb_uart_txq.sv
`timescale 1ns/1ps
module tb_uart_txq;
  localparam int DEPTH = 24;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, loadReq, shiftDone, irqEnReady, irqEnThresh;
  logic [7:0] wrData;
  logic [4:0] thresh;
  logic [7:0] txByte;
  logic       loadAck, txReady, txEmpty, threshHit, irq;
  logic [4:0] count;

  int nChecks = 0;
  int nFail = 0;

  // reference state
  logic [7:0] model[$];
  bit mBusy = 0;
  bit mUnder = 0;

  always #2 clk = ~clk;

  uart_txq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .loadReq(loadReq), .shiftDone(shiftDone), .thresh(thresh),
    .irqEnReady(irqEnReady), .irqEnThresh(irqEnThresh),
    .txByte(txByte), .loadAck(loadAck), .txReady(txReady),
    .txEmpty(txEmpty), .threshHit(threshHit), .count(count), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expHit(input int sz, input logic [4:0] th);
    return (DEPTH - sz) >= int'(th);
  endfunction

  function automatic bit expEmpty(input int sz);
    return mUnder && sz == 0 && !mBusy;
  endfunction

  // one cycle: drive after negedge, check, then advance model as the edge will
  task automatic step(input bit wr, input logic [7:0] d, input bit ld, input bit dn);
    int sz;
    bit push, pop;
    @(negedge clk);
    wrEn = wr; wrData = d; loadReq = ld; shiftDone = dn;
    #0.5;
    sz = model.size();
    push = wr && sz < DEPTH;
    pop  = ld && sz > 0;
    chk("R1 count", count, sz);
    chk("R3 txReady", txReady, sz < DEPTH);
    chk("R4 loadAck", loadAck, pop);
    if (sz > 0) chk("R4 txByte order", txByte, model[0]);
    chk("R5 txEmpty", txEmpty, expEmpty(sz));
    chk("R7 threshHit", threshHit, expHit(sz, thresh));
    chk("R8 irq", irq, (irqEnReady && sz < DEPTH) || (irqEnThresh && expHit(sz, thresh)));
    if (pop) void'(model.pop_front());
    if (push) model.push_back(d);
    if (push) mUnder = 0;
    else if (dn && sz == 0) mUnder = 1;
    if (pop) mBusy = 1;
    else if (dn) mBusy = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    rstN = 0; wrEn = 0; wrData = 0; loadReq = 0; shiftDone = 0;
    thresh = 5'd8; irqEnReady = 1; irqEnThresh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #0.5;
    chk("R9 reset count", count, 0);
    chk("R9 reset txReady", txReady, 1);
    chk("R9 reset txEmpty", txEmpty, 0);

    // R4: load request on empty queue
    step(0, 8'h00, 1, 0);
    // R5: finish with empty queue records underrun
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 0);
    chk("R5 txEmpty after underrun", txEmpty, 1);
    // R6: write clears it
    step(1, 8'h11, 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R6 txEmpty cleared by write", txEmpty, 0);
    // write beside an empty finish: write wins
    step(1, 8'h12, 1, 0);
    step(0, 8'h00, 1, 0);
    step(1, 8'h13, 0, 1);
    step(0, 8'h00, 0, 0);
    chk("R6 write beats underrun", txEmpty, 0);

    // fill to full
    irqEnThresh = 1; thresh = 5'd0;
    for (int i = model.size(); i < DEPTH; i++) step(1, 8'(8'h40 + i), 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R2 full count", count, 24);
    chk("R3 full txReady", txReady, 0);
    step(1, 8'hAA, 0, 0);          // R2: ignored
    step(0, 8'h00, 0, 0);
    chk("R2 write when full ignored", count, 24);
    step(1, 8'hBB, 1, 0);          // R10: full, write refused, load served
    step(0, 8'h00, 0, 0);
    chk("R10 full write+load", count, 23);
    step(1, 8'hCC, 1, 0);          // R10: write+load not full
    step(0, 8'h00, 0, 0);
    chk("R10 write+load count held", count, 23);
    thresh = 5'd24;
    while (model.size() > 0) step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 0);

    // constrained random phases: fill bias / drain bias
    for (int ph = 0; ph < 8; ph++) begin
      int wp = (ph % 2 == 0) ? 80 : 20;
      for (int c = 0; c < 600; c++) begin
        if (c % 97 == 0) begin
          thresh = 5'($urandom_range(0, 31));
          irqEnReady = 1'($urandom);
          irqEnThresh = 1'($urandom);
        end
        step($urandom_range(0, 99) < wp, 8'($urandom),
             $urandom_range(0, 99) < (100 - wp), $urandom_range(0, 99) < 30);
      end
    end

    summary();
    $finish;
  end
endmodule